// File: doc/BRIEF.md
# RTC Alarm and Event Interrupt Unit

This block sits beside a real-time clock counter. It watches the counter's current BCD time and date and compares them with two programmable alarm registers. Each alarm field has its own match-enable bit, so software can pick which fields take part in the match. The alarm has no year field, so only seconds, minutes, hours, month and day of month can be compared.

The block also collects five event sources into a status register: the alarm, a per-second event, a time event, a calendar event and an update acknowledge. Software uses separate registers to control the interrupt mask. One register sets mask bits for each one written, another clears them, and the mask itself can be read back. A fourth register clears status bits for each one written. A single interrupt line is high while any status bit with its mask bit set is high. The line can therefore be shared, and a handler can read status and mask to find out whether the interrupt is its own. The time itself is counted elsewhere.

Top module: `rtcai_unit`

## Requirements
- R1: After a synchronous active-low reset, the status is 0, the mask is 0, both alarm registers read 0 (all match enables off) and `irq_o` is 0.
- R2: The time alarm register (address 0) holds BCD seconds in bits 6:0 with enable bit 7, minutes in bits 14:8 with enable bit 15, and hours in bits 21:16 with enable bit 23. Other bits read 0, so writing all ones reads back 0x00BFFFFF.
- R3: The alarm status bit (status bit 0) sets when every enabled alarm field equals the current value. Fields whose enable is off are ignored.
- R4: The alarm status sets only on the cycle where the match first becomes true. If it is cleared while the match still holds, it stays clear until the match ends and then begins again.
- R5: With no alarm field enabled, the alarm status never sets, even when every field value equals the current time.
- R6: A one-cycle pulse on `sec_evt_i`, `time_evt_i`, `cal_evt_i` or `upd_ack_i` sets status bit 1, 2, 3 or 4 respectively on the next clock edge. The status is read at address 2.
- R7: Writing to address 4 sets the mask bits written as one. Writing to address 5 clears the mask bits written as one. Zero bits leave the mask unchanged. The mask reads back at address 6.
- R8: Writing to address 3 clears the status bits written as one. Zero bits leave status unchanged.
- R9: `irq_o` is high exactly when some bit is set in both status and mask. A masked source stays visible in status without raising `irq_o`.
- R10: When an event and a clear of the same status bit arrive in the same cycle, the bit ends up set.
- R11: The date alarm register (address 1) holds the BCD month in bits 20:16 with enable bit 23 and the day of month in bits 29:24 with enable bit 31, and has no year field. Writing all ones reads back 0xBF9F0000. Its fields take part in the match in the same way as the time fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Combinational register read data |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 6 | Current hours, BCD |
| cur_mon_i | input | 5 | Current month, BCD |
| cur_mday_i | input | 6 | Current day of month, BCD |
| sec_evt_i | input | 1 | Per-second event pulse |
| time_evt_i | input | 1 | Time event pulse |
| cal_evt_i | input | 1 | Calendar event pulse |
| upd_ack_i | input | 1 | Update acknowledge pulse |
| irq_o | output | 1 | Shared interrupt line |

## Verification
The assertions check several properties on every cycle:
- the reset values;
- that an event pulse always lands in status, even against a clear in the same cycle;
- that a clear without a competing event takes effect;
- that mask set and clear writes take effect;
- that the interrupt line agrees with status and mask;
- that the alarm hit is a single-cycle edge that never occurs with all enables off.

Other behaviour can only be shown by the bench's scenarios:
- the field layout of the alarm registers;
- that disabled fields are ignored in the match;
- that a cleared alarm stays clear while the match holds and fires again after the match breaks and returns;
- that writing zero bits leaves status and mask unchanged.

// File: rtl/rtcai_pkg.sv
// Package: shared widths, register addresses, status bit positions and
// the alarm field layout used by the RTC alarm/event interrupt unit.
package rtcai_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned NUM_SRC   = 5;
    localparam int unsigned NUM_FLD   = 5;
    localparam int unsigned SEC_W     = 7;
    localparam int unsigned MIN_W     = 7;
    localparam int unsigned HOUR_W    = 6;
    localparam int unsigned MON_W     = 5;
    localparam int unsigned MDAY_W    = 6;
    localparam int unsigned FLD_MAX_W = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_ALM_TIME = 3'd0,
        A_ALM_DATE = 3'd1,
        A_STATUS   = 3'd2,
        A_CLEAR    = 3'd3,
        A_IEN      = 3'd4,
        A_IDIS     = 3'd5,
        A_MASK     = 3'd6
    } reg_addr_e;

    localparam int unsigned ST_ALARM = 0;
    localparam int unsigned ST_SEC   = 1;
    localparam int unsigned ST_TIME  = 2;
    localparam int unsigned ST_CAL   = 3;
    localparam int unsigned ST_UPD   = 4;

    localparam logic [REG_W-1:0] TIME_ALM_MASK = 32'h00BF_FFFF;
    localparam logic [REG_W-1:0] DATE_ALM_MASK = 32'hBF9F_0000;

    // Field positions within the 64-bit word {date alarm, time alarm}.
    localparam int FLD_LSB [NUM_FLD] = '{0, 8, 16, 48, 56};
    localparam int FLD_W   [NUM_FLD] = '{7, 7, 6, 5, 6};
    localparam int FLD_EN  [NUM_FLD] = '{7, 15, 23, 55, 63};
endpackage

// File: rtl/rtcai_alarm_regs.sv
// Module: holds the time and date alarm registers.
// Assumes: one write port; bits outside the defined fields are stored as 0.
module rtcai_alarm_regs
    import rtcai_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_time_i,
    input  logic         we_date_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] time_alm_o,
    output logic [W-1:0] date_alm_o
);
    logic [W-1:0] time_q;
    logic [W-1:0] date_q;

    // Capture alarm register writes, keeping only the defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
            date_q <= '0;
        end else begin
            if (we_time_i) time_q <= wdata_i & W'(TIME_ALM_MASK);
            if (we_date_i) date_q <= wdata_i & W'(DATE_ALM_MASK);
        end
    end

    assign time_alm_o = time_q;
    assign date_alm_o = date_q;
endmodule

// File: rtl/rtcai_alarm_cmp.sv
// Module: per-field alarm compare with enables and rising-edge detection.
// Assumes: the current-time fields are stable between counter updates; a
// hit is a one-cycle pulse on the cycle the enabled match first holds.
module rtcai_alarm_cmp
    import rtcai_pkg::*;
#(
    parameter int unsigned NF = NUM_FLD,
    parameter int unsigned FW = FLD_MAX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NF-1:0][FW-1:0] alm_val_i,
    input  logic [NF-1:0]         alm_en_i,
    input  logic [NF-1:0][FW-1:0] cur_val_i,
    output logic                  hit_o,
    output logic                  any_en_o
);
    logic [NF-1:0] fld_ok;
    logic          match;
    logic          match_q;

    // One comparator per field; a disabled field always agrees.
    for (genvar g = 0; g < NF; g++) begin : g_fld
        assign fld_ok[g] = !alm_en_i[g] || (alm_val_i[g] == cur_val_i[g]);
    end

    assign any_en_o = |alm_en_i;
    assign match    = any_en_o && (&fld_ok);

    // Remember the previous match to fire only on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    assign hit_o = match && !match_q;
endmodule

// File: rtl/rtcai_irq_ctrl.sv
// Module: status register with write-one clear, and the interrupt mask
// with write-one set and clear registers. Drives the shared interrupt.
// Assumes: an event set wins over a clear of the same bit in one cycle.
module rtcai_irq_ctrl #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_we_i,
    input  logic         ien_we_i,
    input  logic         idis_we_i,
    input  logic [N-1:0] wbits_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    logic [N-1:0] status_q;
    logic [N-1:0] mask_q;

    // One status bit per source; a set beats a clear.
    for (genvar i = 0; i < N; i++) begin : g_st
        always_ff @(posedge clk) begin
            if (!rst_n)                          status_q[i] <= 1'b0;
            else if (set_i[i])                   status_q[i] <= 1'b1;
            else if (clr_we_i && wbits_i[i])     status_q[i] <= 1'b0;
        end
    end

    // Mask update from the enable and disable registers.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (ien_we_i)  mask_q <= mask_q | wbits_i;
        else if (idis_we_i) mask_q <= mask_q & ~wbits_i;
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/rtcai_unit.sv
// Module: RTC alarm and event interrupt unit top level.
// Assumes: single-cycle register writes, combinational reads, BCD inputs.
module rtcai_unit
    import rtcai_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic [SEC_W-1:0]  cur_sec_i,
    input  logic [MIN_W-1:0]  cur_min_i,
    input  logic [HOUR_W-1:0] cur_hour_i,
    input  logic [MON_W-1:0]  cur_mon_i,
    input  logic [MDAY_W-1:0] cur_mday_i,
    input  logic              sec_evt_i,
    input  logic              time_evt_i,
    input  logic              cal_evt_i,
    input  logic              upd_ack_i,
    output logic              irq_o
);
    localparam int unsigned CMP_W = 2 * REG_W;

    logic [REG_W-1:0]                   time_alm;
    logic [REG_W-1:0]                   date_alm;
    logic [CMP_W-1:0]                   alm_vec;
    logic [NUM_FLD-1:0][FLD_MAX_W-1:0] alm_val;
    logic [NUM_FLD-1:0][FLD_MAX_W-1:0] cur_val;
    logic [NUM_FLD-1:0]                 alm_en;
    logic                               alarm_hit;
    logic                               alarm_any_en;
    logic [NUM_SRC-1:0]                 src_set;
    logic [NUM_SRC-1:0]                 status_q;
    logic [NUM_SRC-1:0]                 mask_q;
    logic                               we_time, we_date, we_clr, we_ien, we_idis;

    // Write address decode.
    assign we_time = wr_en_i && (wr_addr_i == A_ALM_TIME);
    assign we_date = wr_en_i && (wr_addr_i == A_ALM_DATE);
    assign we_clr  = wr_en_i && (wr_addr_i == A_CLEAR);
    assign we_ien  = wr_en_i && (wr_addr_i == A_IEN);
    assign we_idis = wr_en_i && (wr_addr_i == A_IDIS);

    rtcai_alarm_regs #(.W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_time_i  (we_time),
        .we_date_i  (we_date),
        .wdata_i    (wr_data_i),
        .time_alm_o (time_alm),
        .date_alm_o (date_alm)
    );

    // Split the alarm registers into fields by the package layout.
    assign alm_vec = {date_alm, time_alm};
    for (genvar g = 0; g < NUM_FLD; g++) begin : g_split
        assign alm_val[g] = FLD_MAX_W'(alm_vec[FLD_LSB[g] +: FLD_W[g]]);
        assign alm_en[g]  = alm_vec[FLD_EN[g]];
    end

    assign cur_val[0] = FLD_MAX_W'(cur_sec_i);
    assign cur_val[1] = FLD_MAX_W'(cur_min_i);
    assign cur_val[2] = FLD_MAX_W'(cur_hour_i);
    assign cur_val[3] = FLD_MAX_W'(cur_mon_i);
    assign cur_val[4] = FLD_MAX_W'(cur_mday_i);

    rtcai_alarm_cmp #(.NF(NUM_FLD), .FW(FLD_MAX_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .alm_val_i (alm_val),
        .alm_en_i  (alm_en),
        .cur_val_i (cur_val),
        .hit_o     (alarm_hit),
        .any_en_o  (alarm_any_en)
    );

    // Gather the event sources in status bit order.
    assign src_set[ST_ALARM] = alarm_hit;
    assign src_set[ST_SEC]   = sec_evt_i;
    assign src_set[ST_TIME]  = time_evt_i;
    assign src_set[ST_CAL]   = cal_evt_i;
    assign src_set[ST_UPD]   = upd_ack_i;

    rtcai_irq_ctrl #(.N(NUM_SRC)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (src_set),
        .clr_we_i  (we_clr),
        .ien_we_i  (we_ien),
        .idis_we_i (we_idis),
        .wbits_i   (wr_data_i[NUM_SRC-1:0]),
        .status_o  (status_q),
        .mask_o    (mask_q),
        .irq_o     (irq_o)
    );

    // Read data multiplexer; write-only addresses read as zero.
    always_comb begin
        case (rd_addr_i)
            A_ALM_TIME: rd_data_o = time_alm;
            A_ALM_DATE: rd_data_o = date_alm;
            A_STATUS:   rd_data_o = REG_W'(status_q);
            A_MASK:     rd_data_o = REG_W'(mask_q);
            default:    rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/rtcai_unit_chk.sv
// Module: property checker bound to rtcai_unit.
// Assumes: it observes the top's ports and its status, mask and alarm nets.
module rtcai_unit_chk
    import rtcai_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [NUM_SRC-1:0] wr_bits,
    input logic               sec_evt,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] mask,
    input logic               irq,
    input logic               alarm_hit,
    input logic               alarm_any_en
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && mask == '0 && !irq));

    p_hit_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> !alarm_hit);

    p_no_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_any_en |-> !alarm_hit);

    p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_evt |=> status[ST_SEC]);

    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IEN) |=> ((mask & $past(wr_bits)) == $past(wr_bits)));

    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IDIS) |=> ((mask & $past(wr_bits)) == '0));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CLEAR && wr_bits[ST_SEC] && !sec_evt) |=> !status[ST_SEC]);

    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status & mask) != '0));

    p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) == '0) |-> !irq);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CLEAR && wr_bits[ST_SEC] && sec_evt) |=> status[ST_SEC]);
endmodule

bind rtcai_unit rtcai_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en_i),
    .wr_addr      (wr_addr_i),
    .wr_bits      (wr_data_i[rtcai_pkg::NUM_SRC-1:0]),
    .sec_evt      (sec_evt_i),
    .status       (status_q),
    .mask         (mask_q),
    .irq          (irq_o),
    .alarm_hit    (alarm_hit),
    .alarm_any_en (alarm_any_en)
);

// File: tb/rtcai_unit_bench.sv
// Directed bench for rtcai_unit: one task per scenario, each self-checking.
module rtcai_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [6:0]  cur_sec = '0;
    logic [6:0]  cur_min = '0;
    logic [5:0]  cur_hour = '0;
    logic [4:0]  cur_mon = '0;
    logic [5:0]  cur_mday = '0;
    logic        sec_evt = 1'b0, time_evt = 1'b0, cal_evt = 1'b0, upd_ack = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtcai_unit u_rtcai_unit (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .cur_sec_i(cur_sec), .cur_min_i(cur_min), .cur_hour_i(cur_hour),
        .cur_mon_i(cur_mon), .cur_mday_i(cur_mday),
        .sec_evt_i(sec_evt), .time_evt_i(time_evt), .cal_evt_i(cal_evt),
        .upd_ack_i(upd_ack), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(3'd2, v); check("R1 status", v, 32'h0);
        reg_read(3'd6, v); check("R1 mask", v, 32'h0);
        reg_read(3'd0, v); check("R1 time alarm", v, 32'h0);
        reg_read(3'd1, v); check("R1 date alarm", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_layout;
        logic [31:0] v;
        reg_write(3'd0, 32'hFFFF_FFFF);
        reg_read(3'd0, v); check("R2 time alarm layout", v, 32'h00BF_FFFF);
        reg_write(3'd1, 32'hFFFF_FFFF);
        reg_read(3'd1, v); check("R11 date alarm layout", v, 32'hBF9F_0000);
        reg_write(3'd1, 32'h0);
        reg_write(3'd0, 32'h0);
    endtask

    task automatic t_events;
        logic [31:0] v;
        @(negedge clk); sec_evt = 1'b1; time_evt = 1'b1; cal_evt = 1'b1; upd_ack = 1'b1;
        @(negedge clk); sec_evt = 1'b0; time_evt = 1'b0; cal_evt = 1'b0; upd_ack = 1'b0;
        reg_read(3'd2, v); check("R6 event bits", v, 32'h1E);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        reg_write(3'd3, 32'h06);
        reg_read(3'd2, v); check("R8 partial clear", v, 32'h18);
        reg_write(3'd3, 32'h00);
        reg_read(3'd2, v); check("R8 zero write no effect", v, 32'h18);
        reg_write(3'd3, 32'h1F);
        reg_read(3'd2, v); check("R8 full clear", v, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        reg_write(3'd4, 32'h05);
        reg_read(3'd6, v); check("R7 enable sets", v, 32'h05);
        reg_write(3'd4, 32'h02);
        reg_read(3'd6, v); check("R7 enable zeros no effect", v, 32'h07);
        reg_write(3'd5, 32'h04);
        reg_read(3'd6, v); check("R7 disable clears", v, 32'h03);
        reg_write(3'd5, 32'h03);
        reg_read(3'd6, v); check("R7 disable all", v, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        @(negedge clk); sec_evt = 1'b1;
        @(negedge clk); sec_evt = 1'b0;
        check("R9 masked source no irq", {31'b0, irq}, 32'h0);
        reg_write(3'd4, 32'h02);
        check("R9 unmasked source irq", {31'b0, irq}, 32'h1);
        reg_write(3'd5, 32'h02);
        check("R9 masked again no irq", {31'b0, irq}, 32'h0);
        reg_read(3'd2, v); check("R9 status still visible", v, 32'h02);
        reg_write(3'd4, 32'h02);
        reg_write(3'd3, 32'h02);
        check("R9 cleared status no irq", {31'b0, irq}, 32'h0);
        reg_write(3'd5, 32'h1F);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h02; sec_evt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; sec_evt = 1'b0;
        reg_read(3'd2, v); check("R10 set beats clear", v, 32'h02);
        reg_write(3'd3, 32'h02);
        reg_read(3'd2, v); check("R10 later clear", v, 32'h0);
    endtask

    task automatic t_time_alarm;
        logic [31:0] v;
        cur_hour = 6'h10; cur_min = 7'h15; cur_sec = 7'h29; cur_mon = 5'h01; cur_mday = 6'h01;
        reg_write(3'd3, 32'h1F);
        // sec 0x30 and min 0x15 enabled, hour 0x23 not enabled
        reg_write(3'd0, 32'h0023_95B0);
        idle(2);
        reg_read(3'd2, v); check("R3 no match yet", v, 32'h0);
        cur_sec = 7'h30;
        @(negedge clk);
        reg_read(3'd2, v); check("R3 alarm on enabled fields", v, 32'h01);
        reg_write(3'd3, 32'h01);
        idle(3);
        reg_read(3'd2, v); check("R4 no re-set during match", v, 32'h0);
        cur_sec = 7'h31;
        @(negedge clk);
        cur_sec = 7'h30;
        @(negedge clk);
        reg_read(3'd2, v); check("R4 fires after match returns", v, 32'h01);
        reg_write(3'd0, 32'h0);
        reg_write(3'd3, 32'h1F);
    endtask

    task automatic t_date_alarm;
        logic [31:0] v;
        cur_mon = 5'h12; cur_mday = 6'h24;
        reg_write(3'd1, 32'hA592_0000);
        idle(2);
        reg_read(3'd2, v); check("R11 day differs no alarm", v, 32'h0);
        cur_mday = 6'h25;
        @(negedge clk);
        reg_read(3'd2, v); check("R11 date alarm fires", v, 32'h01);
        reg_write(3'd1, 32'h0);
        reg_write(3'd3, 32'h1F);
    endtask

    task automatic t_no_enable;
        logic [31:0] v;
        cur_hour = 6'h08; cur_min = 7'h00; cur_sec = 7'h10; cur_mon = 5'h03; cur_mday = 6'h07;
        reg_write(3'd1, 32'h0703_0000);
        reg_write(3'd0, 32'h0008_0010);
        idle(3);
        cur_sec = 7'h11;
        @(negedge clk);
        cur_sec = 7'h10;
        idle(2);
        reg_read(3'd2, v); check("R5 no enables never fires", v, 32'h0);
        reg_write(3'd0, 32'h0);
        reg_write(3'd1, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_events();
        t_clear();
        t_mask();
        t_irq();
        t_set_wins();
        t_time_alarm();
        t_date_alarm();
        t_no_enable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule